// File: doc/BRIEF.md
# Programmable Pad Output, Tristate and Input-Capture Cell

This block is the output side of a bidirectional pad cell, with the input return path included. Internal logic presents two data bits and two tristate bits on every clock. A storage pair sits on the data path and another on the tristate path. A parameter sets each path to one of three variants: direct (combinational pass-through of the first bit), registered (first bit captured on the rising edge), or double data rate. In double data rate mode, both bits are captured on the rising edge and the pad carries the first bit while the clock is high and the second while it is low.

The pad is modelled as a data value `padData` plus an active-low driver enable `padOeN`. When `padOeN` is 1, the chip-edge buffer floats the pad (high-Z). The value returning from the pad enters on `padIn`. It reaches internal logic unregistered on `inDirect`, and through two capture registers on `iq1` and `iq2`. In double data rate input mode, `iq2` samples on the falling edge. Every signal entering the cell has its own inversion parameter.

Top module: `iocell_out`

## Requirements
- R1: While `rstN` is low, the registered and double data rate paths hold data 0, tristate 1 (`padOeN` all ones, driver off), and `iq1` = `iq2` = 0. The reset acts asynchronously.
- R2: With OUT_MODE = PATH_DIRECT (encoding 0), `padData` equals the effective `o1` in the same cycle, and `o2` has no effect.
- R3: With TRI_MODE = PATH_DIRECT, `padOeN` equals the effective `t1` in the same cycle, and `t2` has no effect. A 1 on any bit means that pad bit is high-Z.
- R4: With OUT_MODE = PATH_REG (encoding 1), `padData` equals the effective `o1` captured at the most recent rising edge, through both clock phases, and `o2` has no effect.
- R5: With TRI_MODE = PATH_REG, `padOeN` equals the effective `t1` captured at the most recent rising edge, and `t2` has no effect.
- R6: With OUT_MODE = PATH_DDR (encoding 2), `padData` shows the effective `o1` captured at the last rising edge while `clk` is high. While `clk` is low, it shows the effective `o2` captured at that same rising edge.
- R7: With TRI_MODE = PATH_DDR, `padOeN` shows the captured effective `t1` while `clk` is high and the captured effective `t2` while `clk` is low.
- R8: Each of `o1`, `o2`, `t1`, `t2` and `padIn` is bitwise inverted before use when its parameter INV_O1, INV_O2, INV_T1, INV_T2 or INV_IN is 1. The effective value is the input XOR that bit.
- R9: `inDirect` equals the effective `padIn` combinationally.
- R10: With IN_DDR = 0, `iq1` and `iq2` both hold the effective `padIn` sampled at the last rising edge.
- R11: With IN_DDR = 1, `iq1` holds the effective `padIn` from the last rising edge and `iq2` holds it from the last falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock; its level also selects the double data rate phase |
| rstN | input | 1 | Asynchronous active-low reset |
| o1 | input | W | First data bit per pad from internal logic |
| o2 | input | W | Second data bit per pad (used in double data rate mode only) |
| t1 | input | W | First tristate bit per pad, 1 = float |
| t2 | input | W | Second tristate bit per pad (double data rate mode only) |
| padIn | input | W | Value returning from the pad |
| padData | output | W | Value the pad driver puts out |
| padOeN | output | W | Active-low driver enable; 1 leaves the pad high-Z |
| inDirect | output | W | Unregistered pad value to internal logic |
| iq1 | output | W | Pad value captured on the rising edge |
| iq2 | output | W | Pad value captured on the falling edge (double data rate) or rising edge |

## Verification
Three instances run side by side on shared stimulus, one in each path mode, with different inversion settings. The first stimulus pattern holds `o1` and `o2` at opposite constant values, with `t1` low and `t2` high. Only the correct phase assignment of double data rate bits passes this pattern, and it shows whether the single-rate paths ignore the second bit. The second pattern toggles complementary bits every cycle, which separates a one-cycle capture from a stale or combinational path. The third pattern is random traffic; it also changes `padIn` in both half-periods so that falling-edge input capture differs from rising-edge capture. A reset is asserted in the middle of the run to recheck the reset state.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

  // Variant of a storage-pair path
  typedef enum logic [1:0] {
    PATH_DIRECT = 2'd0,
    PATH_REG    = 2'd1,
    PATH_DDR    = 2'd2
  } pathMode_e;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic phaseHigh;   // clock is in its high half-period
  } cellStrobe_t;

endpackage

// File: rtl/iocell_pair.sv
module iocell_pair
  import iocell_pkg::*;
#(
  parameter int        W         = 2,
  parameter pathMode_e MODE      = PATH_DDR,
  parameter bit        RESET_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         phaseHigh,
  input  logic [W-1:0] d1,
  input  logic [W-1:0] d2,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] RST_WORD = {W{RESET_VAL}};

  generate
    if (MODE == PATH_DIRECT) begin : g_direct
      assign q = d1;
    end else if (MODE == PATH_REG) begin : g_reg
      logic [W-1:0] riseQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) riseQ <= RST_WORD;
        else       riseQ <= d1;
      end
      assign q = riseQ;
    end else begin : g_ddr
      logic [W-1:0] riseQ;
      logic [W-1:0] holdQ;
      logic [W-1:0] fallQ;
      // both bits are taken at the rising edge
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          riseQ <= RST_WORD;
          holdQ <= RST_WORD;
        end else begin
          riseQ <= d1;
          holdQ <= d2;
        end
      end
      // second bit is retimed to the falling edge before the phase mux
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) fallQ <= RST_WORD;
        else       fallQ <= holdQ;
      end
      assign q = phaseHigh ? riseQ : fallQ;
    end
  endgenerate

endmodule

// File: rtl/iocell_ctrl.sv
module iocell_ctrl
  import iocell_pkg::*;
#(
  parameter int        W        = 2,
  parameter pathMode_e TRI_MODE = PATH_DDR,
  parameter bit        INV_T1   = 1'b0,
  parameter bit        INV_T2   = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] t1,
  input  logic [W-1:0] t2,
  output cellStrobe_t  strobe,
  output logic [W-1:0] padOeN
);

  localparam logic [W-1:0] T1_FLIP = {W{INV_T1}};
  localparam logic [W-1:0] T2_FLIP = {W{INV_T2}};

  logic [W-1:0] t1Eff;
  logic [W-1:0] t2Eff;

  assign strobe.phaseHigh = clk;
  assign t1Eff = t1 ^ T1_FLIP;
  assign t2Eff = t2 ^ T2_FLIP;

  // tristate registers come out of reset with the driver off
  iocell_pair #(
    .W        (W),
    .MODE     (TRI_MODE),
    .RESET_VAL(1'b1)
  ) triPair (
    .clk      (clk),
    .rstN     (rstN),
    .phaseHigh(strobe.phaseHigh),
    .d1       (t1Eff),
    .d2       (t2Eff),
    .q        (padOeN)
  );

endmodule

// File: rtl/iocell_dp.sv
module iocell_dp
  import iocell_pkg::*;
#(
  parameter int        W        = 2,
  parameter pathMode_e OUT_MODE = PATH_DDR,
  parameter bit        IN_DDR   = 1'b1,
  parameter bit        INV_O1   = 1'b0,
  parameter bit        INV_O2   = 1'b0,
  parameter bit        INV_IN   = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  cellStrobe_t  strobe,
  input  logic [W-1:0] o1,
  input  logic [W-1:0] o2,
  input  logic [W-1:0] padIn,
  output logic [W-1:0] padData,
  output logic [W-1:0] inDirect,
  output logic [W-1:0] iq1,
  output logic [W-1:0] iq2
);

  localparam logic [W-1:0] O1_FLIP = {W{INV_O1}};
  localparam logic [W-1:0] O2_FLIP = {W{INV_O2}};
  localparam logic [W-1:0] IN_FLIP = {W{INV_IN}};

  logic [W-1:0] o1Eff;
  logic [W-1:0] o2Eff;
  logic [W-1:0] padEff;

  assign o1Eff  = o1 ^ O1_FLIP;
  assign o2Eff  = o2 ^ O2_FLIP;
  assign padEff = padIn ^ IN_FLIP;

  iocell_pair #(
    .W        (W),
    .MODE     (OUT_MODE),
    .RESET_VAL(1'b0)
  ) outPair (
    .clk      (clk),
    .rstN     (rstN),
    .phaseHigh(strobe.phaseHigh),
    .d1       (o1Eff),
    .d2       (o2Eff),
    .q        (padData)
  );

  assign inDirect = padEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) iq1 <= '0;
    else       iq1 <= padEff;
  end

  generate
    if (IN_DDR) begin : g_inFall
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) iq2 <= '0;
        else       iq2 <= padEff;
      end
    end else begin : g_inRise
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) iq2 <= '0;
        else       iq2 <= padEff;
      end
    end
  endgenerate

endmodule

// File: rtl/iocell_out.sv
module iocell_out
  import iocell_pkg::*;
#(
  parameter int        W        = 2,
  parameter pathMode_e OUT_MODE = PATH_DDR,
  parameter pathMode_e TRI_MODE = PATH_DDR,
  parameter bit        IN_DDR   = 1'b1,
  parameter bit        INV_O1   = 1'b0,
  parameter bit        INV_O2   = 1'b0,
  parameter bit        INV_T1   = 1'b0,
  parameter bit        INV_T2   = 1'b0,
  parameter bit        INV_IN   = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] o1,
  input  logic [W-1:0] o2,
  input  logic [W-1:0] t1,
  input  logic [W-1:0] t2,
  input  logic [W-1:0] padIn,
  output logic [W-1:0] padData,
  output logic [W-1:0] padOeN,
  output logic [W-1:0] inDirect,
  output logic [W-1:0] iq1,
  output logic [W-1:0] iq2
);

  cellStrobe_t strobe;

  iocell_ctrl #(
    .W       (W),
    .TRI_MODE(TRI_MODE),
    .INV_T1  (INV_T1),
    .INV_T2  (INV_T2)
  ) ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .t1    (t1),
    .t2    (t2),
    .strobe(strobe),
    .padOeN(padOeN)
  );

  iocell_dp #(
    .W       (W),
    .OUT_MODE(OUT_MODE),
    .IN_DDR  (IN_DDR),
    .INV_O1  (INV_O1),
    .INV_O2  (INV_O2),
    .INV_IN  (INV_IN)
  ) dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .o1      (o1),
    .o2      (o2),
    .padIn   (padIn),
    .padData (padData),
    .inDirect(inDirect),
    .iq1     (iq1),
    .iq2     (iq2)
  );

endmodule

// File: rtl/iocell_out_chk.sv
module iocell_out_chk
  import iocell_pkg::*;
#(
  parameter int        W        = 2,
  parameter pathMode_e OUT_MODE = PATH_DDR,
  parameter pathMode_e TRI_MODE = PATH_DDR,
  parameter bit        IN_DDR   = 1'b1,
  parameter bit        INV_O1   = 1'b0,
  parameter bit        INV_O2   = 1'b0,
  parameter bit        INV_T1   = 1'b0,
  parameter bit        INV_T2   = 1'b0,
  parameter bit        INV_IN   = 1'b0
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] o1,
  input logic [W-1:0] o2,
  input logic [W-1:0] t1,
  input logic [W-1:0] t2,
  input logic [W-1:0] padIn,
  input logic [W-1:0] padData,
  input logic [W-1:0] padOeN,
  input logic [W-1:0] inDirect,
  input logic [W-1:0] iq1,
  input logic [W-1:0] iq2
);

  localparam logic [W-1:0] O1_F = {W{INV_O1}};
  localparam logic [W-1:0] O2_F = {W{INV_O2}};
  localparam logic [W-1:0] T1_F = {W{INV_T1}};
  localparam logic [W-1:0] T2_F = {W{INV_T2}};
  localparam logic [W-1:0] IN_F = {W{INV_IN}};

  // one rising (falling) edge has passed out of reset
  logic pastValid;
  logic pastValidN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) pastValidN <= 1'b0;
    else       pastValidN <= 1'b1;
  end

  // R9
  in_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    inDirect == (padIn ^ IN_F));

  // R10 R11
  iq1_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> iq1 == ($past(padIn) ^ IN_F));

  generate
    if (IN_DDR) begin : g_inDdr
      // R11
      iq2_fall_chk: assert property (@(negedge clk) disable iff (!rstN)
        pastValidN |-> iq2 == ($past(padIn) ^ IN_F));
    end else begin : g_inReg
      // R10
      iq2_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
        pastValid |-> iq2 == ($past(padIn) ^ IN_F));
    end

    if (OUT_MODE == PATH_DIRECT) begin : g_outDir
      // R2
      direct_data_chk: assert property (@(posedge clk) disable iff (!rstN)
        padData == (o1 ^ O1_F));
    end else if (OUT_MODE == PATH_REG) begin : g_outReg
      // R4
      reg_data_chk: assert property (@(posedge clk) disable iff (!rstN)
        pastValid |-> padData == ($past(o1) ^ O1_F));
    end else begin : g_outDdr
      // R6: sampled just before the edge the clock is low, so the second bit shows
      ddr_low_data_chk: assert property (@(posedge clk) disable iff (!rstN)
        pastValid |-> padData == ($past(o2) ^ O2_F));
    end

    if (TRI_MODE == PATH_DIRECT) begin : g_triDir
      // R3
      direct_tri_chk: assert property (@(posedge clk) disable iff (!rstN)
        padOeN == (t1 ^ T1_F));
    end else if (TRI_MODE == PATH_REG) begin : g_triReg
      // R5
      reg_tri_chk: assert property (@(posedge clk) disable iff (!rstN)
        pastValid |-> padOeN == ($past(t1) ^ T1_F));
    end else begin : g_triDdr
      // R7
      ddr_low_tri_chk: assert property (@(posedge clk) disable iff (!rstN)
        pastValid |-> padOeN == ($past(t2) ^ T2_F));
    end
  endgenerate

endmodule

bind iocell_out iocell_out_chk #(
  .W       (W),
  .OUT_MODE(OUT_MODE),
  .TRI_MODE(TRI_MODE),
  .IN_DDR  (IN_DDR),
  .INV_O1  (INV_O1),
  .INV_O2  (INV_O2),
  .INV_T1  (INV_T1),
  .INV_T2  (INV_T2),
  .INV_IN  (INV_IN)
) chk (.*);

// File: tb/iocell_out_test.sv
`timescale 1ns/1ps
module iocell_out_test;
  import iocell_pkg::*;

  localparam int W = 2;
  localparam int N = 3;
  // instance 0: DDR everywhere; 1: registered; 2: direct out/tri, rising-edge input
  localparam int OUT_M [N] = '{2, 1, 0};
  localparam int TRI_M [N] = '{2, 1, 0};
  localparam bit [N-1:0] IN_D  = 3'b001;
  localparam bit [N-1:0] INVO1 = 3'b010;
  localparam bit [N-1:0] INVO2 = 3'b001;
  localparam bit [N-1:0] INVT1 = 3'b100;
  localparam bit [N-1:0] INVT2 = 3'b001;
  localparam bit [N-1:0] INVIN = 3'b010;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic [W-1:0] o1 = '0, o2 = '0, t1 = '0, t2 = '0, padIn = '0;

  logic [W-1:0] padDataW [N];
  logic [W-1:0] padOeNW  [N];
  logic [W-1:0] inDirW   [N];
  logic [W-1:0] iq1W     [N];
  logic [W-1:0] iq2W     [N];

  // reference state: effective register contents
  logic [W-1:0] mHi [N], mLo [N], mTHi [N], mTLo [N], mIq1 [N], mIq2 [N];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  iocell_out #(.W(W), .OUT_MODE(pathMode_e'(OUT_M[0])), .TRI_MODE(pathMode_e'(TRI_M[0])),
    .IN_DDR(IN_D[0]), .INV_O1(INVO1[0]), .INV_O2(INVO2[0]), .INV_T1(INVT1[0]),
    .INV_T2(INVT2[0]), .INV_IN(INVIN[0])) uut (
    .clk(clk), .rstN(rstN), .o1(o1), .o2(o2), .t1(t1), .t2(t2), .padIn(padIn),
    .padData(padDataW[0]), .padOeN(padOeNW[0]), .inDirect(inDirW[0]),
    .iq1(iq1W[0]), .iq2(iq2W[0]));

  iocell_out #(.W(W), .OUT_MODE(pathMode_e'(OUT_M[1])), .TRI_MODE(pathMode_e'(TRI_M[1])),
    .IN_DDR(IN_D[1]), .INV_O1(INVO1[1]), .INV_O2(INVO2[1]), .INV_T1(INVT1[1]),
    .INV_T2(INVT2[1]), .INV_IN(INVIN[1])) uutReg (
    .clk(clk), .rstN(rstN), .o1(o1), .o2(o2), .t1(t1), .t2(t2), .padIn(padIn),
    .padData(padDataW[1]), .padOeN(padOeNW[1]), .inDirect(inDirW[1]),
    .iq1(iq1W[1]), .iq2(iq2W[1]));

  iocell_out #(.W(W), .OUT_MODE(pathMode_e'(OUT_M[2])), .TRI_MODE(pathMode_e'(TRI_M[2])),
    .IN_DDR(IN_D[2]), .INV_O1(INVO1[2]), .INV_O2(INVO2[2]), .INV_T1(INVT1[2]),
    .INV_T2(INVT2[2]), .INV_IN(INVIN[2])) uutDir (
    .clk(clk), .rstN(rstN), .o1(o1), .o2(o2), .t1(t1), .t2(t2), .padIn(padIn),
    .padData(padDataW[2]), .padOeN(padOeNW[2]), .inDirect(inDirW[2]),
    .iq1(iq1W[2]), .iq2(iq2W[2]));

  function automatic logic [W-1:0] flip(input logic [W-1:0] v, input bit inv);
    return inv ? ~v : v;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin
      mHi[i] = '0; mLo[i] = '0; mTHi[i] = '1; mTLo[i] = '1; mIq1[i] = '0; mIq2[i] = '0;
    end
  endtask

  task automatic modelRise();
    if (!rstN) modelReset();
    else for (int i = 0; i < N; i++) begin
      mHi[i]  = flip(o1, INVO1[i]);
      mLo[i]  = flip(o2, INVO2[i]);
      mTHi[i] = flip(t1, INVT1[i]);
      mTLo[i] = flip(t2, INVT2[i]);
      mIq1[i] = flip(padIn, INVIN[i]);
      if (!IN_D[i]) mIq2[i] = flip(padIn, INVIN[i]);
    end
  endtask

  task automatic modelFall();
    if (rstN) for (int i = 0; i < N; i++)
      if (IN_D[i]) mIq2[i] = flip(padIn, INVIN[i]);
  endtask

  task automatic checkOne(input string tag, input string what, input int inst,
                          input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s inst%0d %s: actual %b expected %b at %0t", tag, inst, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input bit high);
    for (int i = 0; i < N; i++) begin
      logic [W-1:0] expD, expT;
      string tagD, tagT, tagI;
      case (OUT_M[i])
        0: begin expD = flip(o1, INVO1[i]); tagD = INVO1[i] ? "R2/R8" : "R2"; end
        1: begin expD = mHi[i]; tagD = INVO1[i] ? "R4/R8" : "R4"; end
        default: begin expD = high ? mHi[i] : mLo[i]; tagD = INVO2[i] ? "R6/R8" : "R6"; end
      endcase
      case (TRI_M[i])
        0: begin expT = flip(t1, INVT1[i]); tagT = INVT1[i] ? "R3/R8" : "R3"; end
        1: begin expT = mTHi[i]; tagT = "R5"; end
        default: begin expT = high ? mTHi[i] : mTLo[i]; tagT = INVT2[i] ? "R7/R8" : "R7"; end
      endcase
      tagI = IN_D[i] ? "R11" : "R10";
      if (!rstN) begin
        if (OUT_M[i] != 0) tagD = "R1";
        if (TRI_M[i] != 0) tagT = "R1";
        tagI = "R1";
      end
      checkOne(tagD, "padData", i, padDataW[i], expD);
      checkOne(tagT, "padOeN", i, padOeNW[i], expT);
      checkOne(INVIN[i] ? "R9/R8" : "R9", "inDirect", i, inDirW[i], flip(padIn, INVIN[i]));
      checkOne(tagI, "iq1", i, iq1W[i], mIq1[i]);
      checkOne(tagI, "iq2", i, iq2W[i], mIq2[i]);
    end
  endtask

  initial begin
    modelReset();
    #0.5 rstN = 1'b0;
    modelReset();
    for (int cyc = 0; cyc < 300; cyc++) begin
      logic [W-1:0] padB;
      @(posedge clk);
      modelRise();
      #1;
      if (cyc < 40) begin
        o1 = '1; o2 = '0; t1 = '0; t2 = '1; padIn = 2'b10; padB = 2'b01;
      end else if (cyc < 80) begin
        o1 = cyc[0] ? 2'b01 : 2'b10; o2 = ~o1; t1 = '0; t2 = '0;
        padIn = cyc[0] ? '1 : '0; padB = ~padIn;
      end else begin
        o1 = W'($urandom); o2 = W'($urandom); t1 = W'($urandom); t2 = W'($urandom);
        padIn = W'($urandom); padB = W'($urandom);
      end
      rstN = !(cyc < 4 || (cyc >= 150 && cyc < 153));
      if (!rstN) modelReset();
      #1;
      checkAll(1'b1);
      @(negedge clk);
      modelFall();
      #0.5 padIn = padB;
      #1;
      checkAll(1'b0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule